// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This controller sits on the host side of a flash device and decides when an embedded program or erase operation has finished. After software or another engine has launched the operation, a one-cycle `start` pulse hands the poller the address to watch and the width of the status word. The poller then reads that address over a simple request/acknowledge bus and compares the toggle bit between consecutive reads. The operation is complete once the bit stops changing.

When the toggle bit is still moving and the error bit is set, the poller does not fail at once, because the two bits may have changed together. It takes two fresh reads and compares their toggle bits. If they match, the result is success. If they differ, the result is failure: the poller writes a reset command to the device and then raises `fail`. A read-count watchdog ends polling that never settles with the same reset write, and flags that ending as a timeout.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `fail`, `timeout`, `rd_req` and `wr_req` are all 0 until a `start` is seen.
- R2: `start` captures `poll_addr` with bit 0 forced to 0. Every read and the reset write present that even address on `bus_addr`.
- R3: `word_mode` is sampled at `start`. When it is 0, the toggle bit is `bus_rdata[6]` and the error bit is `bus_rdata[5]`. When it is 1, they are bits 14 and 13, and bits 6 and 5 are ignored.
- R4: If two consecutive reads return the same toggle bit, `done` pulses and no write is issued, whatever the error bit holds.
- R5: If the toggle bit differs and the error bit of the newer read is 0, one more read is taken and compared with the newest earlier read.
- R6: If the toggle bit differs and the error bit of the newer read is 1, two more reads are taken. If their toggle bits match, `done` pulses.
- R7: If those two confirming reads differ, one write of data 0x00F0 is issued, and `fail` pulses after it is acknowledged.
- R8: If the toggle bit is still changing with the error bit 0 on read number MAX_READS, polling stops. The reset write is issued, and then `fail` and `timeout` pulse together.
- R9: `done` and `fail` are single-cycle pulses and never occur together. `busy` is 1 from the cycle after `start` and falls in the cycle the pulse appears.
- R10: A `start` pulse while `busy` is 1 is ignored. It changes neither the polled address nor the bit positions.
- R11: A request stays asserted with a stable address until `bus_ack`. `rd_req` and `wr_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| word_mode | input | 1 | 0: status in bits 6/5, 1: status in bits 14/13 |
| poll_addr | input | AW | Address inside the busy region |
| rd_req | output | 1 | Read request, held until acknowledged |
| wr_req | output | 1 | Reset-write request, held until acknowledged |
| bus_addr | output | AW | Even address for the current request |
| bus_wdata | output | 16 | Write data (0x00F0 reset command) |
| bus_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| bus_rdata | input | 16 | Status word returned by a read |
| busy | output | 1 | Polling in progress |
| done | output | 1 | Pulse: operation completed |
| fail | output | 1 | Pulse: operation failed or timed out |
| timeout | output | 1 | Pulse with `fail` when the watchdog ended polling |

## Verification
The in-module properties assume that `bus_ack` only rises while a request is pending, stays high for one cycle, and carries valid `bus_rdata` in that same cycle. The bench's bus responder follows this rule. It answers each request on the next falling edge, drops the acknowledge on the edge after, and never acknowledges when nothing is requested. Status words come from scripted sequences, and a strictly alternating source drives the watchdog case. Each `start` is a one-cycle pulse. The one exception is the deliberate pulse during a busy run, which is included to show that the controller ignores it.

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int AW        = 16,
  parameter int MAX_READS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          word_mode,
  input  logic [AW-1:0] poll_addr,
  output logic          rd_req,
  output logic          wr_req,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic          bus_ack,
  input  logic [15:0]   bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          timeout
);
  localparam int CW = $clog2(MAX_READS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_READS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_FIRST, S_RD_NEXT, S_CF_FIRST, S_CF_SECOND, S_RESET
  } state_t;

  state_t        state;
  logic [AW-1:0] addr_q;
  logic          wm_q, prev_q, tmo_q;
  logic [CW-1:0] cnt_q;

  wire tog     = wm_q ? bus_rdata[14] : bus_rdata[6];
  wire err     = wm_q ? bus_rdata[13] : bus_rdata[5];
  wire got     = bus_ack && rd_req;
  wire changed = tog != prev_q;

  assign rd_req    = state inside {S_RD_FIRST, S_RD_NEXT, S_CF_FIRST, S_CF_SECOND};
  assign wr_req    = state == S_RESET;
  assign bus_addr  = addr_q;
  assign bus_wdata = 16'h00F0;
  assign busy      = state != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      wm_q    <= 1'b0;
      prev_q  <= 1'b0;
      tmo_q   <= 1'b0;
      cnt_q   <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          addr_q <= {poll_addr[AW-1:1], 1'b0};
          wm_q   <= word_mode;
          cnt_q  <= '0;
          tmo_q  <= 1'b0;
          state  <= S_RD_FIRST;
        end
        S_RD_FIRST: if (got) begin
          prev_q <= tog;
          cnt_q  <= cnt_q + 1'b1;
          state  <= S_RD_NEXT;
        end
        S_RD_NEXT: if (got) begin
          prev_q <= tog;
          cnt_q  <= cnt_q + 1'b1;
          if (!changed) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (err) begin
            state <= S_CF_FIRST;
          end else if (cnt_q >= LAST) begin
            tmo_q <= 1'b1;
            state <= S_RESET;
          end
        end
        S_CF_FIRST: if (got) begin
          prev_q <= tog;
          state  <= S_CF_SECOND;
        end
        S_CF_SECOND: if (got) begin
          if (changed) state <= S_RESET;
          else begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_RESET: if (bus_ack) begin
          fail    <= 1'b1;
          timeout <= tmo_q;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_req_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !bus_ack) |=> (rd_req && $stable(bus_addr)));
  a_r2_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_req) |-> !bus_addr[0]);
  a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_fail_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);
  a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> (!busy && $past(busy)));
  a_r8_tmo_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> fail);
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(bus_addr));
endmodule

// File: tb/toggle_poll_ctrl_tb.sv
module toggle_poll_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        word_mode = 1'b0;
  logic [15:0] poll_addr = '0;
  logic        rd_req, wr_req, busy, done, fail, timeout;
  logic [15:0] bus_addr, bus_wdata;
  logic        bus_ack = 1'b0;
  logic [15:0] bus_rdata = '0;

  toggle_poll_ctrl #(.AW(16), .MAX_READS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
    .poll_addr(poll_addr), .rd_req(rd_req), .wr_req(wr_req),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .fail(fail),
    .timeout(timeout));

  always #2 clk = ~clk;

  typedef struct packed {
    logic             wm;
    logic [15:0]      addr;
    logic [3:0][15:0] seq;
    logic [2:0]       nrd;
    logic             fl;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0101, '{16'h0000, 16'h0000, 16'h0000, 16'h0000}, 3'd2, 1'b0},
    '{1'b0, 16'h2000, '{16'h0040, 16'h0040, 16'h0000, 16'h0040}, 3'd4, 1'b0},
    '{1'b0, 16'h0302, '{16'h0060, 16'h0060, 16'h0020, 16'h0040}, 3'd4, 1'b0},
    '{1'b0, 16'h0457, '{16'h0040, 16'h0000, 16'h0060, 16'h0000}, 3'd4, 1'b1},
    '{1'b1, 16'h0AB1, '{16'h0000, 16'h0000, 16'h0000, 16'h0040}, 3'd2, 1'b0},
    '{1'b1, 16'h7FFF, '{16'h2000, 16'h6000, 16'h2000, 16'h4000}, 3'd4, 1'b1},
    '{1'b0, 16'h0010, '{16'h0000, 16'h0000, 16'h0020, 16'h0020}, 3'd2, 1'b0},
    '{1'b0, 16'h0C0C, '{16'h0000, 16'h0000, 16'h0000, 16'h4000}, 3'd2, 1'b0},
    '{1'b1, 16'h0E03, '{16'h0000, 16'h0000, 16'h0020, 16'h4000}, 3'd3, 1'b0}
  };

  int tests = 0, failed = 0;
  int n_rd, n_wr, addr_bad;
  logic [15:0] exp_addr, last_wdata;
  logic [3:0][15:0] cur_seq;
  logic alt = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (rd_req) begin
      if (alt) bus_rdata = n_rd[0] ? 16'h0000 : 16'h0040;
      else bus_rdata = (n_rd < 4) ? cur_seq[n_rd] : 16'h0000;
      if (bus_addr != exp_addr) addr_bad++;
      n_rd++;
      bus_ack = 1'b1;
    end else if (wr_req) begin
      last_wdata = bus_wdata;
      if (bus_addr != exp_addr) addr_bad++;
      n_wr++;
      bus_ack = 1'b1;
    end
  end

  task automatic run_op(input logic wm, input logic [15:0] addr, input logic exp_fail,
                        input logic exp_tmo, input int exp_nrd, input logic inject);
    int cyc;
    logic got_tmo;
    n_rd = 0; n_wr = 0; addr_bad = 0; last_wdata = '0;
    exp_addr = {addr[15:1], 1'b0};
    @(negedge clk);
    start = 1'b1; word_mode = wm; poll_addr = addr;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    cyc = 0;
    while (!(done || fail) && cyc < 500) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 5) begin
        start = 1'b1; word_mode = ~wm; poll_addr = addr ^ 16'h0F00;
      end else if (inject && cyc == 6) start = 1'b0;
    end
    got_tmo = timeout;
    chk(done == !exp_fail && fail == exp_fail, "R4/R7 outcome", {done, fail}, {!exp_fail, exp_fail});
    chk(busy == 1'b0, "R9 busy low at outcome", busy, 0);
    chk(n_rd == exp_nrd, "R5/R6/R3 read count", n_rd, exp_nrd);
    chk(n_wr == (exp_fail ? 1 : 0), "R7 reset write count", n_wr, exp_fail ? 1 : 0);
    if (exp_fail) chk(last_wdata == 16'h00F0, "R7 reset data", last_wdata, 16'h00F0);
    chk(got_tmo == exp_tmo, "R8 timeout flag", got_tmo, exp_tmo);
    chk(addr_bad == 0, inject ? "R10 address kept" : "R2 even address", addr_bad, 0);
    @(negedge clk);
    chk(!done && !fail && !busy, "R9 single pulse", {done, fail, busy}, 0);
  endtask

  initial begin
    #800000;
    failed++;
    $display("[TB] FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, fail, timeout, rd_req, wr_req} == 6'b0, "R1 reset state",
        {busy, done, fail, timeout, rd_req, wr_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, fail, timeout, rd_req, wr_req} == 6'b0, "R1 idle after reset",
        {busy, done, fail, timeout, rd_req, wr_req}, 0);

    for (int i = 0; i < NV; i++) begin
      cur_seq = VEC[i].seq;
      alt = 1'b0;
      run_op(VEC[i].wm, VEC[i].addr, VEC[i].fl, 1'b0, int'(VEC[i].nrd), 1'b0);
    end

    alt = 1'b1;
    run_op(1'b0, 16'h1235, 1'b1, 1'b1, 16, 1'b0);
    run_op(1'b0, 16'h2221, 1'b1, 1'b1, 16, 1'b1);

    alt = 1'b0;
    cur_seq = '{16'h0000, 16'h0000, 16'h0040, 16'h0040};
    run_op(1'b0, 16'h0001, 1'b0, 1'b0, 2, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule